// File: doc/BRIEF.md
# Word-to-byte bus access adapter

The adapter sits between a 16-bit register access port and a peripheral bus that may be wired either 8 or 16 bits wide. A request gives a byte offset, a direction and, for writes, a 16-bit word. When the bus is wide, the request becomes one word cycle at the offset. When the bus is narrow, the request becomes two byte cycles, at the offset and then at offset+1. A build parameter chooses which half of the word goes to the lower address. Reads put the two returned bytes back into the word using the same placement.

Every bus cycle holds its address, direction and data until the peripheral raises `bus_ready`. A one-cycle `done` pulse follows the last completed cycle, and the assembled read word is valid on `rd_data` in that cycle. The controller is a four-state machine. IDLE accepts a request and goes to LEAD. LEAD waits for ready and then goes to TRAIL in byte mode or to WRAP in word mode. TRAIL waits for ready and goes to WRAP. WRAP raises `done` and returns to IDLE. Named transitions: accept (IDLE to LEAD), lead_word (LEAD to WRAP), lead_byte (LEAD to TRAIL), trail_done (TRAIL to WRAP) and retire (WRAP to IDLE).

Top module: `word_byte_adapter`

## Requirements
- R1: After reset `busy`, `done` and `bus_cyc` are all 0.
- R2: A request is accepted only in IDLE. A `req_valid` seen while `busy` is 1 starts no bus cycle, either then or after the running request ends.
- R3: With the width select at 1 (wide), a request makes exactly one bus cycle with `bus_wide`=1, `bus_addr` equal to the offset, the full write word on `bus_wdata` and the full `bus_rdata` word as the read result.
- R4: With HI_FIRST=1 and the width select at 0, a write makes two byte cycles. The first is at the offset with the high byte on `bus_wdata[7:0]`. The second is at offset+1 with the low byte. `bus_wdata[15:8]` is 0 in byte cycles.
- R5: With HI_FIRST=0 and the width select at 0, the low byte goes to the offset and the high byte goes to offset+1.
- R6: In byte mode, a read takes `bus_rdata[7:0]` from each cycle. It places the byte from the offset cycle in the high half when HI_FIRST=1 and in the low half when HI_FIRST=0. The byte from the offset+1 cycle goes in the other half.
- R7: A bus cycle holds `bus_cyc`, `bus_addr`, `bus_we` and `bus_wdata` unchanged for as long as `bus_ready` is 0.
- R8: `done` is 1 for exactly one cycle, the cycle after the edge at which the last bus cycle saw `bus_ready`=1. `rd_data` holds the read result in that cycle.
- R9: The width select is sampled at acceptance. Changing it during a request does not change the number of cycles or `bus_wide`.
- R10: `busy` is 1 from the cycle after acceptance up to and including the `done` cycle, and 0 in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 16 | Write word |
| wide_sel | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Assembled read word |
| bus_cyc | output | 1 | Bus cycle active |
| bus_we | output | 1 | Bus cycle direction |
| bus_wide | output | 1 | Current cycle is a word cycle |
| bus_addr | output | ADDR_W | Bus byte address |
| bus_wdata | output | 16 | Bus write data (byte in [7:0] when narrow) |
| bus_rdata | input | 16 | Bus read data |
| bus_ready | input | 1 | Peripheral completes the current cycle |

## Verification
A wrong state in the controller shows at the ports in the same cycle. A missing TRAIL phase shows as `done` arriving one cycle early with no offset+1 cycle. An extra phase shows as a third `bus_cyc`, and a stuck phase shows as `busy` staying high. If the byte placement is swapped, the lead bus cycle carries the wrong byte at the moment it starts, and `rd_data` is wrong in the `done` cycle. Both parameter settings run side by side on the same stimulus, so any mismatch in byte order is reported on the first byte-mode access.

// File: rtl/wba_pkg.sv
package wba_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2,
        ST_WRAP  = 2'd3
    } wba_state_e;
endpackage

// File: rtl/wba_ctrl.sv
module wba_ctrl
    import wba_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wide_sel,
    input  logic              bus_ready,
    output logic              load,
    output logic              in_trail,
    output logic              lat_wide,
    output logic              cap_word,
    output logic              cap_lead,
    output logic              cap_trail,
    output logic              busy,
    output logic              done,
    output logic              bus_cyc,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr
);
    wba_state_e        state, nxt;
    logic [ADDR_W-1:0] addr_q;
    logic              we_q, wide_q;

    assign load = (state == ST_IDLE) && req_valid;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (req_valid) nxt = ST_LEAD;
            ST_LEAD:  if (bus_ready) nxt = wide_q ? ST_WRAP : ST_TRAIL;
            ST_TRAIL: if (bus_ready) nxt = ST_WRAP;
            ST_WRAP:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            we_q   <= 1'b0;
            wide_q <= 1'b0;
        end else begin
            state <= nxt;
            if (load) begin
                addr_q <= req_addr;
                we_q   <= req_write;
                wide_q <= wide_sel;
            end
        end
    end

    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        bus_cyc   = 1'b0;
        in_trail  = 1'b0;
        cap_word  = 1'b0;
        cap_lead  = 1'b0;
        cap_trail = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_LEAD: begin
                busy      = 1'b1;
                bus_cyc   = 1'b1;
                cap_word  = bus_ready && wide_q;
                cap_lead  = bus_ready && !wide_q;
            end
            ST_TRAIL: begin
                busy      = 1'b1;
                bus_cyc   = 1'b1;
                in_trail  = 1'b1;
                cap_trail = bus_ready;
            end
            ST_WRAP: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    assign bus_we   = we_q;
    assign lat_wide = wide_q;
    assign bus_addr = addr_q + ADDR_W'(in_trail);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    done_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_cyc && bus_ready));
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_ready) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_we)));
    // R4
    next_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEAD && bus_ready && !wide_q) |=> (bus_addr == $past(bus_addr) + 1'b1));
    // R3
    word_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEAD && bus_ready && wide_q) |=> (done && !bus_cyc));
    // R10
    cyc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> busy);
endmodule

// File: rtl/wba_lane.sv
module wba_lane #(
    parameter bit HI_FIRST = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [15:0] req_wdata,
    input  logic        in_trail,
    input  logic        lat_wide,
    input  logic        cap_word,
    input  logic        cap_lead,
    input  logic        cap_trail,
    input  logic [15:0] bus_rdata,
    output logic [15:0] bus_wdata,
    output logic [15:0] rd_data
);
    logic [15:0] wdata_q, rd_q;
    logic        pick_hi;

    assign pick_hi = HI_FIRST ? !in_trail : in_trail;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
            rd_q    <= '0;
        end else begin
            if (load) wdata_q <= req_wdata;
            if (cap_word) rd_q <= bus_rdata;
            if (cap_lead || cap_trail) begin
                if (pick_hi) rd_q[15:8] <= bus_rdata[7:0];
                else         rd_q[7:0]  <= bus_rdata[7:0];
            end
        end
    end

    always_comb begin
        if (lat_wide) bus_wdata = wdata_q;
        else          bus_wdata = {8'h00, pick_hi ? wdata_q[15:8] : wdata_q[7:0]};
    end

    assign rd_data = rd_q;

    // R4
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lat_wide) |-> (bus_wdata[15:8] == 8'h00));
endmodule

// File: rtl/word_byte_adapter.sv
module word_byte_adapter #(
    parameter int ADDR_W   = 8,
    parameter bit HI_FIRST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic              wide_sel,
    output logic              busy,
    output logic              done,
    output logic [15:0]       rd_data,
    output logic              bus_cyc,
    output logic              bus_we,
    output logic              bus_wide,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [15:0]       bus_wdata,
    input  logic [15:0]       bus_rdata,
    input  logic              bus_ready
);
    logic load, in_trail, lat_wide, cap_word, cap_lead, cap_trail;

    wba_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .wide_sel(wide_sel), .bus_ready(bus_ready),
        .load(load), .in_trail(in_trail), .lat_wide(lat_wide),
        .cap_word(cap_word), .cap_lead(cap_lead), .cap_trail(cap_trail),
        .busy(busy), .done(done), .bus_cyc(bus_cyc), .bus_we(bus_we),
        .bus_addr(bus_addr)
    );

    wba_lane #(.HI_FIRST(HI_FIRST)) u_lane (
        .clk(clk), .rst_n(rst_n), .load(load), .req_wdata(req_wdata),
        .in_trail(in_trail), .lat_wide(lat_wide), .cap_word(cap_word),
        .cap_lead(cap_lead), .cap_trail(cap_trail), .bus_rdata(bus_rdata),
        .bus_wdata(bus_wdata), .rd_data(rd_data)
    );

    assign bus_wide = lat_wide;
endmodule

// File: tb/sim_word_byte_adapter.sv
module sim_word_byte_adapter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, wide_sel = 1'b0, bus_ready = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0, bus_rdata = '0;
    logic        busy0, done0, cyc0, we0, wide0, busy1, done1, cyc1, we1, wide1;
    logic [15:0] rd0, rd1, wd0, wd1;
    logic [7:0]  ad0, ad1;
    int          total = 0, bad = 0;

    always #10 clk = ~clk;

    word_byte_adapter #(.ADDR_W(8), .HI_FIRST(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .wide_sel(wide_sel),
        .busy(busy0), .done(done0), .rd_data(rd0), .bus_cyc(cyc0), .bus_we(we0),
        .bus_wide(wide0), .bus_addr(ad0), .bus_wdata(wd0), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready));

    word_byte_adapter #(.ADDR_W(8), .HI_FIRST(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .wide_sel(wide_sel),
        .busy(busy1), .done(done1), .rd_data(rd1), .bus_cyc(cyc1), .bus_we(we1),
        .bus_wide(wide1), .bus_addr(ad1), .bus_wdata(wd1), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_cycle(input string tag, input logic [7:0] ea0, input logic [15:0] ed0,
                               input logic [7:0] ea1, input logic [15:0] ed1, input logic we, input logic wide);
        chk(cyc0 && cyc1, {tag, " bus_cyc"}, {cyc0, cyc1}, 2'b11);
        chk(ad0 == ea0, {tag, " u0 addr"}, ad0, ea0);
        chk(ad1 == ea1, {tag, " u1 addr"}, ad1, ea1);
        if (we) begin
            chk(wd0 == ed0, {tag, " u0 wdata"}, wd0, ed0);
            chk(wd1 == ed1, {tag, " u1 wdata"}, wd1, ed1);
        end
        chk(we0 == we && we1 == we, {tag, " bus_we"}, {we0, we1}, {we, we});
        chk(wide0 == wide && wide1 == wide, "R9 bus_wide held", {wide0, wide1}, {wide, wide});
        chk(busy0 && busy1, "R10 busy during cycle", {busy0, busy1}, 2'b11);
    endtask

    // one request; waits = ready-low cycles before each completion; poke = stray req while busy;
    // flip = toggle width select mid-request
    task automatic access(input logic we, input logic [7:0] a, input logic [15:0] w, input logic wide,
                          input int waits, input logic [7:0] b0, input logic [7:0] b1,
                          input logic poke, input logic flip);
        logic [15:0] e0, e1;
        @(negedge clk);
        req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = w; wide_sel = wide;
        @(negedge clk);
        req_valid = 1'b0;
        if (flip) wide_sel = ~wide;
        if (wide) begin
            check_cycle("R3 word cycle", a, w, a, w, we, 1'b1);
            bus_rdata = {b1, b0};
        end else begin
            check_cycle("R4 lead byte", a, {8'h00, w[15:8]}, a, {8'h00, w[7:0]}, we, 1'b0);
            check_cycle("R5 lead byte", a, {8'h00, w[15:8]}, a, {8'h00, w[7:0]}, we, 1'b0);
            bus_rdata = {8'hEE, b0};
        end
        for (int i = 0; i < waits; i++) begin
            if (poke && i == 0) begin req_valid = 1'b1; req_addr = a ^ 8'h80; end
            @(negedge clk);
            req_valid = 1'b0;
            chk(cyc0 && ad0 == a, "R7 lead held", ad0, a);
            chk(!done0 && !done1, "R8 no early done", {done0, done1}, 2'b00);
        end
        bus_ready = 1'b1;
        @(negedge clk);
        bus_ready = 1'b0;
        if (!wide) begin
            check_cycle("R4 trail byte", a + 8'd1, {8'h00, w[7:0]}, a + 8'd1, {8'h00, w[15:8]}, we, 1'b0);
            check_cycle("R5 trail byte", a + 8'd1, {8'h00, w[7:0]}, a + 8'd1, {8'h00, w[15:8]}, we, 1'b0);
            bus_rdata = {8'h11, b1};
            for (int i = 0; i < waits; i++) begin
                @(negedge clk);
                chk(cyc0 && ad0 == a + 8'd1, "R7 trail held", ad0, a + 8'd1);
            end
            bus_ready = 1'b1;
            @(negedge clk);
            bus_ready = 1'b0;
        end
        chk(done0 && done1, "R8 done pulse", {done0, done1}, 2'b11);
        chk(!cyc0 && !cyc1, "R8 no bus cycle in done", {cyc0, cyc1}, 2'b00);
        chk(busy0 && busy1, "R10 busy in done cycle", {busy0, busy1}, 2'b11);
        if (!we) begin
            e0 = wide ? {b1, b0} : {b0, b1};
            e1 = {b1, b0};
            chk(rd0 == e0, wide ? "R3 read word u0" : "R6 read u0", rd0, e0);
            chk(rd1 == e1, wide ? "R3 read word u1" : "R6 read u1", rd1, e1);
        end
        @(negedge clk);
        chk(!done0 && !done1, "R8 done one cycle", {done0, done1}, 2'b00);
        chk(!busy0 && !busy1, "R10 idle after done", {busy0, busy1}, 2'b00);
        chk(!cyc0 && !cyc1, "R2 no restart", {cyc0, cyc1}, 2'b00);
        wide_sel = 1'b0;
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy0 && !done0 && !cyc0 && !busy1 && !done1 && !cyc1, "R1 reset state",
            {busy0, done0, cyc0}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        test_reset();
        access(1'b1, 8'h10, 16'hA1B2, 1'b0, 0, 8'h00, 8'h00, 1'b0, 1'b0);
        access(1'b0, 8'h20, 16'h0000, 1'b0, 2, 8'h5A, 8'hC3, 1'b0, 1'b0);
        access(1'b1, 8'h40, 16'h1234, 1'b1, 1, 8'h00, 8'h00, 1'b0, 1'b0);
        access(1'b0, 8'h40, 16'h0000, 1'b1, 0, 8'h77, 8'h99, 1'b0, 1'b0);
        access(1'b1, 8'hFE, 16'hBEEF, 1'b0, 3, 8'h00, 8'h00, 1'b1, 1'b0);
        access(1'b0, 8'h08, 16'h0000, 1'b0, 1, 8'h3C, 8'h4D, 1'b0, 1'b1);
        access(1'b0, 8'h0C, 16'h0000, 1'b1, 1, 8'h21, 8'h43, 1'b1, 1'b1);
        $display("%0d/%0d checks passed", total - bad, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", total - bad, total);
        $finish;
    end
endmodule